// File: doc/BRIEF.md
# Wide-to-Narrow Bus Width Adapter

This block attaches a byte-wide peripheral to a 32-bit processor data bus. Its behaviour is fixed at build time by a bit mask over the wide bus. When the mask covers one byte lane, the peripheral appears on that lane only. Every processor access becomes exactly one peripheral access, and the rest of a read word is filled with a constant. When the mask covers every bit, the adapter packs the peripheral into the wide bus instead. Each processor access becomes four byte accesses to consecutive peripheral addresses. On a read the four returned bytes are assembled into one word.

On the processor side a request is presented with `cpu_valid` and held until `cpu_ready` pulses. The address is a word offset. On the peripheral side, `per_stb` is held with a stable address and stable write data until `per_ack` pulses. A small sequencer with states idle, transfer and done counts the byte beats. A new request is taken only once the sequencer is back in idle.

Top module: `bus_width_adapter`

## Requirements
- R1: After reset, `cpu_ready` and `per_stb` are both low, and no peripheral access takes place while `cpu_valid` stays low.
- R2: In lane mode a read returns the peripheral byte on the lane the mask selects. With mask 0x0000FF00 that is bits 15:8, and with mask 0xFF000000 it is bits 31:24.
- R3: In lane mode each processor access causes exactly one peripheral access, and `per_addr` equals the processor word offset, zero-extended.
- R4: In lane mode a write drives `per_wdata` from the selected lane of `cpu_wdata`. The other bytes of `cpu_wdata` do not reach the peripheral.
- R5: With mask 0xFFFFFFFF (packed mode) each processor access causes four peripheral accesses. Their addresses are offset*4+0, +1, +2 and +3, issued in that order.
- R6: A packed read places the byte returned by beat i in bits 8i+7:8i of `cpu_rdata`, so the word is little-endian.
- R7: A packed write sends bits 8i+7:8i of `cpu_wdata` on beat i.
- R8: `cpu_ready` is high for exactly one cycle, and only after the last peripheral acknowledge of the access. While `per_stb` waits for `per_ack`, the address, the write data and the direction stay stable.
- R9: In lane mode the non-selected bytes of a read word equal the build-time fill value: all ones when FILL_ONES is 1, all zeros when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Request present; held until cpu_ready |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word offset of the access |
| cpu_wdata | input | CPU_DW | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | CPU_DW | Read data, valid while cpu_ready is high |
| per_stb | output | 1 | Peripheral access strobe, held until per_ack |
| per_write | output | 1 | Peripheral access direction |
| per_addr | output | AW+log2(CPU_DW/PER_DW) | Peripheral byte address |
| per_wdata | output | PER_DW | Peripheral write byte |
| per_rdata | input | PER_DW | Peripheral read byte, sampled with per_ack |
| per_ack | input | 1 | Peripheral completion pulse |

## Verification
The bench builds three copies with CPU_DW=32, PER_DW=8 and AW=6. The first has mask 0xFFFFFFFF, which gives the four-beat packed sequencing and the byte ordering. The second has mask 0x0000FF00 with FILL_ONES=1, and the third has mask 0xFF000000 with FILL_ONES=0. Together the two lane copies reach both fill values and both an inner lane and the top lane. Each copy is served by a peripheral model with a different acknowledge latency, so the strobe-hold rule is tested at several wait lengths.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } seq_st_e;
endpackage

// File: rtl/bwa_seq.sv
module bwa_seq
    import bwa_pkg::*;
#(
    parameter int AW    = 6,
    parameter int BW    = 2,
    parameter int BEATS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_valid,
    input  logic          cpu_write,
    input  logic [AW-1:0] cpu_addr,
    input  logic          per_ack,
    output logic          accept,
    output logic          cap,
    output logic          per_stb,
    output logic          cpu_ready,
    output logic [BW-1:0] beat,
    output logic [AW-1:0] addr_q,
    output logic          wr_q
);
    localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

    typedef struct packed {
        seq_st_e       st;
        logic [BW-1:0] beat;
        logic [AW-1:0] addr;
        logic          wr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        accept = 1'b0;
        cap    = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (cpu_valid) begin
                    accept    = 1'b1;
                    s_d.st    = ST_XFER;
                    s_d.beat  = '0;
                    s_d.addr  = cpu_addr;
                    s_d.wr    = cpu_write;
                end
            end
            ST_XFER: begin
                if (per_ack) begin
                    cap = 1'b1;
                    if (s_q.beat == LAST) s_d.st = ST_DONE;
                    else s_d.beat = s_q.beat + 1'b1;
                end
            end
            ST_DONE: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= ST_IDLE;
            s_q.beat <= '0;
            s_q.addr <= '0;
            s_q.wr   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign per_stb   = (s_q.st == ST_XFER);
    assign cpu_ready = (s_q.st == ST_DONE);
    assign beat      = s_q.beat;
    assign addr_q    = s_q.addr;
    assign wr_q      = s_q.wr;
endmodule

// File: rtl/bwa_wsel.sv
module bwa_wsel #(
    parameter int CPU_DW = 32,
    parameter int PER_DW = 8,
    parameter int LOG    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CPU_DW-1:0] cpu_wdata,
    input  logic [LOG-1:0]    sel,
    output logic [PER_DW-1:0] per_wdata
);
    logic [CPU_DW-1:0] wd_d, wd_q;

    always_comb begin
        wd_d = wd_q;
        if (load) wd_d = cpu_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end

    assign per_wdata = wd_q[sel*PER_DW +: PER_DW];
endmodule

// File: rtl/bwa_rpack.sv
module bwa_rpack #(
    parameter int CPU_DW    = 32,
    parameter int PER_DW    = 8,
    parameter int LOG       = 2,
    parameter int LANES     = 4,
    parameter bit PACKED    = 1'b1,
    parameter int LANE      = 0,
    parameter bit FILL_ONES = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [LOG-1:0]    sel,
    input  logic [PER_DW-1:0] per_rdata,
    output logic [CPU_DW-1:0] cpu_rdata
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (PACKED || i == LANE) begin : g_live
            logic [PER_DW-1:0] b_d, b_q;
            always_comb begin
                b_d = b_q;
                if (cap && sel == LOG'(i)) b_d = per_rdata;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) b_q <= '0;
                else        b_q <= b_d;
            end
            assign cpu_rdata[i*PER_DW +: PER_DW] = b_q;
        end else begin : g_fill
            assign cpu_rdata[i*PER_DW +: PER_DW] = {PER_DW{FILL_ONES}};
        end
    end
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter #(
    parameter int                 CPU_DW    = 32,
    parameter int                 PER_DW    = 8,
    parameter int                 AW        = 6,
    parameter logic [CPU_DW-1:0]  LANE_MASK = '1,
    parameter bit                 FILL_ONES = 1'b0
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cpu_valid,
    input  logic                                   cpu_write,
    input  logic [AW-1:0]                          cpu_addr,
    input  logic [CPU_DW-1:0]                      cpu_wdata,
    output logic                                   cpu_ready,
    output logic [CPU_DW-1:0]                      cpu_rdata,
    output logic                                   per_stb,
    output logic                                   per_write,
    output logic [AW+$clog2(CPU_DW/PER_DW)-1:0]    per_addr,
    output logic [PER_DW-1:0]                      per_wdata,
    input  logic [PER_DW-1:0]                      per_rdata,
    input  logic                                   per_ack
);
    localparam int LANES = CPU_DW / PER_DW;
    localparam int LOG   = $clog2(LANES);

    function automatic int lowest_lane(input logic [CPU_DW-1:0] m);
        int r;
        r = 0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (m[i*PER_DW]) r = i;
        end
        return r;
    endfunction

    localparam bit PACKED = (LANE_MASK == {CPU_DW{1'b1}});
    localparam int BEATS  = PACKED ? LANES : 1;
    localparam int PA_W   = AW + LOG;
    localparam int LANE   = lowest_lane(LANE_MASK);

    logic           accept, cap;
    logic [LOG-1:0] beat, lane_sel;
    logic [AW-1:0]  addr_q;
    logic           wr_q;

    bwa_seq #(.AW(AW), .BW(LOG), .BEATS(BEATS)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .per_ack(per_ack),
        .accept(accept), .cap(cap), .per_stb(per_stb), .cpu_ready(cpu_ready),
        .beat(beat), .addr_q(addr_q), .wr_q(wr_q)
    );

    if (PACKED) begin : g_packed
        assign lane_sel = beat;
        assign per_addr = {addr_q, beat};
    end else begin : g_lane
        assign lane_sel = LOG'(LANE);
        assign per_addr = PA_W'(addr_q);
    end

    assign per_write = wr_q;

    bwa_wsel #(.CPU_DW(CPU_DW), .PER_DW(PER_DW), .LOG(LOG)) u_wsel (
        .clk(clk), .rst_n(rst_n), .load(accept), .cpu_wdata(cpu_wdata),
        .sel(lane_sel), .per_wdata(per_wdata)
    );

    bwa_rpack #(
        .CPU_DW(CPU_DW), .PER_DW(PER_DW), .LOG(LOG), .LANES(LANES),
        .PACKED(PACKED), .LANE(LANE), .FILL_ONES(FILL_ONES)
    ) u_rpack (
        .clk(clk), .rst_n(rst_n), .cap(cap), .sel(lane_sel),
        .per_rdata(per_rdata), .cpu_rdata(cpu_rdata)
    );
endmodule

// File: rtl/bwa_chk.sv
module bwa_chk #(
    parameter int BEATS  = 4,
    parameter int PA_W   = 8,
    parameter int PER_DW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              per_stb,
    input logic              per_write,
    input logic              per_ack,
    input logic [PA_W-1:0]   per_addr,
    input logic [PER_DW-1:0] per_wdata
);
    logic [7:0] ack_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 ack_cnt <= '0;
        else if (cpu_ready)         ack_cnt <= '0;
        else if (per_stb && per_ack) ack_cnt <= ack_cnt + 8'd1;
    end

    AST_STB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        per_stb && !per_ack |=> per_stb); // R8
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        per_stb && !per_ack |=> $stable(per_addr) && $stable(per_wdata) && $stable(per_write)); // R8
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready); // R8
    AST_READY_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !per_stb); // R8
    AST_BEAT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> ack_cnt == 8'(BEATS)); // R3
endmodule

bind bus_width_adapter bwa_chk #(.BEATS(BEATS), .PA_W(PA_W), .PER_DW(PER_DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .per_stb(per_stb),
    .per_write(per_write), .per_ack(per_ack), .per_addr(per_addr), .per_wdata(per_wdata)
);

// File: tb/tb_bus_width_adapter.sv
`timescale 1ns/1ps
module tb_bus_width_adapter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        cv [3];
    logic        cw [3];
    logic [5:0]  ca [3];
    logic [31:0] cwd[3];
    logic        crdy[3];
    logic [31:0] crd[3];
    logic        pstb[3];
    logic        pwr[3];
    logic [7:0]  paddr[3];
    logic [7:0]  pwd[3];
    logic [7:0]  prd[3];
    logic        pack[3];

    logic [7:0] pmem [3][256];
    logic [7:0] alog [3][16];
    int acnt[3];
    int lcnt[3];
    int n_chk = 0;
    int n_fail = 0;

    bus_width_adapter #(.CPU_DW(32), .PER_DW(8), .AW(6), .LANE_MASK(32'hFFFF_FFFF), .FILL_ONES(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cv[0]), .cpu_write(cw[0]), .cpu_addr(ca[0]),
        .cpu_wdata(cwd[0]), .cpu_ready(crdy[0]), .cpu_rdata(crd[0]), .per_stb(pstb[0]),
        .per_write(pwr[0]), .per_addr(paddr[0]), .per_wdata(pwd[0]), .per_rdata(prd[0]), .per_ack(pack[0]));
    bus_width_adapter #(.CPU_DW(32), .PER_DW(8), .AW(6), .LANE_MASK(32'h0000_FF00), .FILL_ONES(1'b1)) dut_lo (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cv[1]), .cpu_write(cw[1]), .cpu_addr(ca[1]),
        .cpu_wdata(cwd[1]), .cpu_ready(crdy[1]), .cpu_rdata(crd[1]), .per_stb(pstb[1]),
        .per_write(pwr[1]), .per_addr(paddr[1]), .per_wdata(pwd[1]), .per_rdata(prd[1]), .per_ack(pack[1]));
    bus_width_adapter #(.CPU_DW(32), .PER_DW(8), .AW(6), .LANE_MASK(32'hFF00_0000), .FILL_ONES(1'b0)) dut_hi (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cv[2]), .cpu_write(cw[2]), .cpu_addr(ca[2]),
        .cpu_wdata(cwd[2]), .cpu_ready(crdy[2]), .cpu_rdata(crd[2]), .per_stb(pstb[2]),
        .per_write(pwr[2]), .per_addr(paddr[2]), .per_wdata(pwd[2]), .per_rdata(prd[2]), .per_ack(pack[2]));

    // Peripheral models: acknowledge after k+1 waiting cycles
    always @(negedge clk) begin
        for (int k = 0; k < 3; k++) begin
            if (!rst_n) begin
                pack[k] = 1'b0;
                lcnt[k] = 0;
            end else if (pack[k]) begin
                pack[k] = 1'b0;
                lcnt[k] = 0;
            end else if (pstb[k]) begin
                if (lcnt[k] == k) begin
                    if (pwr[k]) pmem[k][paddr[k]] = pwd[k];
                    else        prd[k] = pmem[k][paddr[k]];
                    alog[k][acnt[k] % 16] = paddr[k];
                    acnt[k] = acnt[k] + 1;
                    pack[k] = 1'b1;
                end else begin
                    lcnt[k] = lcnt[k] + 1;
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_xfer(input int k, input logic wr, input logic [5:0] addr,
                            input logic [31:0] wdata, input int beats, output logic [31:0] rd);
        int cyc;
        int a0;
        a0 = acnt[k];
        @(negedge clk);
        cv[k] = 1'b1; cw[k] = wr; ca[k] = addr; cwd[k] = wdata;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!crdy[k] && cyc < 1000);
        rd = crd[k];
        check("R8 ready arrives after last ack", 32'(acnt[k] - a0), 32'(beats));
        cv[k] = 1'b0;
        @(negedge clk);
        check("R8 ready lasts one cycle", {31'd0, crdy[k]}, 32'd0);
    endtask

    task automatic t_reset();
        for (int k = 0; k < 3; k++) begin
            check("R1 ready low after reset", {31'd0, crdy[k]}, 32'd0);
            check("R1 strobe low after reset", {31'd0, pstb[k]}, 32'd0);
        end
    endtask

    task automatic t_idle();
        int a[3];
        for (int k = 0; k < 3; k++) a[k] = acnt[k];
        repeat (10) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            check("R1 no access while idle", 32'(acnt[k] - a[k]), 32'd0);
            check("R1 strobe stays low while idle", {31'd0, pstb[k]}, 32'd0);
        end
    endtask

    task automatic t_packed_read(input logic [5:0] addr, input logic [31:0] word);
        logic [31:0] rd;
        int a0;
        for (int i = 0; i < 4; i++) pmem[0][{addr, 2'(i)}] = word[i*8 +: 8];
        a0 = acnt[0];
        cpu_xfer(0, 1'b0, addr, 32'h0, 4, rd);
        check("R6 packed read word", rd, word);
        for (int i = 0; i < 4; i++)
            check("R5 packed beat address order", {24'd0, alog[0][(a0 + i) % 16]}, {24'd0, addr, 2'(i)});
    endtask

    task automatic t_packed_write(input logic [5:0] addr, input logic [31:0] word);
        logic [31:0] rd;
        int a0;
        a0 = acnt[0];
        cpu_xfer(0, 1'b1, addr, word, 4, rd);
        for (int i = 0; i < 4; i++) begin
            check("R7 packed write byte", {24'd0, pmem[0][{addr, 2'(i)}]}, {24'd0, word[i*8 +: 8]});
            check("R5 packed write address order", {24'd0, alog[0][(a0 + i) % 16]}, {24'd0, addr, 2'(i)});
        end
    endtask

    task automatic t_lane_read(input int k, input logic [5:0] addr, input logic [7:0] b,
                               input logic [31:0] exp);
        logic [31:0] rd;
        int a0;
        pmem[k][{2'b00, addr}] = b;
        a0 = acnt[k];
        cpu_xfer(k, 1'b0, addr, 32'h0, 1, rd);
        check("R2 R9 lane read word with fill", rd, exp);
        check("R3 lane read single access", 32'(acnt[k] - a0), 32'd1);
        check("R3 lane address is word offset", {24'd0, alog[k][a0 % 16]}, {26'd0, addr});
    endtask

    task automatic t_lane_write(input int k, input logic [5:0] addr, input logic [31:0] word,
                                input logic [7:0] exp);
        logic [31:0] rd;
        int a0;
        pmem[k][{2'b00, addr}] = 8'h00;
        a0 = acnt[k];
        cpu_xfer(k, 1'b1, addr, word, 1, rd);
        check("R4 lane write byte", {24'd0, pmem[k][{2'b00, addr}]}, {24'd0, exp});
        check("R3 lane write single access", 32'(acnt[k] - a0), 32'd1);
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin
            cv[k] = 1'b0; cw[k] = 1'b0; ca[k] = '0; cwd[k] = '0; acnt[k] = 0; lcnt[k] = 0;
            pack[k] = 1'b0; prd[k] = '0;
            for (int j = 0; j < 256; j++) pmem[k][j] = 8'(j ^ 8'h5C);
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_idle();
        t_packed_read(6'd5, 32'h8142_C3E4);
        t_packed_read(6'd63, 32'h0102_0304);
        t_packed_write(6'd9, 32'hA1B2_C3D4);
        t_packed_read(6'd9, 32'hA1B2_C3D4);
        t_packed_write(6'd0, 32'hFF00_FF00);
        t_lane_read(1, 6'd7, 8'h5A, 32'hFFFF_5AFF);
        t_lane_read(2, 6'd3, 8'hC3, 32'hC300_0000);
        t_lane_read(1, 6'd40, 8'h00, 32'hFFFF_00FF);
        t_lane_read(2, 6'd41, 8'hFF, 32'hFF00_0000);
        t_lane_write(1, 6'd12, 32'h1122_3344, 8'h33);
        t_lane_write(2, 6'd13, 32'h1122_3344, 8'h11);
        t_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired before the test sequence ended");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule